// File: doc/BRIEF.md
# Boot Strap Capture and Bus-Width Latch

This block records two boot-time configuration pins once reset has been released, and keeps their values until reset is asserted again. The first pin chooses whether code is fetched from on-chip memory or from an external memory. The second pin chooses the width of the external data bus. While reset is active, the block asks the pad for a weak pull-up on the width pin, so a board that leaves the pin floating gets the wide bus.

The raw reset input is brought into the oscillator clock domain by a two-stage synchroniser. Reset asserts at once and releases on a clock edge. When the synchronised reset falls, the controller moves from `ST_HOLD` to `ST_SETTLE` (transition T_RELEASE). It then counts three clock cycles, during which both pins must keep their level, and captures them on the edge that ends the third cycle. At that edge it moves to `ST_RUN` (transition T_CAPTURE). In `ST_RUN` the code-mode pin is handed back to the system as an active-high bus-wait input. Software can also overwrite the bus-width setting through a one-bit write port. Asserting reset returns the controller to `ST_HOLD` from any state (transition T_RESET). No other transitions exist.

Top module: `strap_latch`

## Requirements
- R1: From reset assertion until capture, `code_internal` and `bus_wide` both read 1.
- R2: `rst_raw` is taken low between two rising clock edges. The pins are then sampled on the sixth rising edge after that point: two edges for the synchroniser, one for T_RELEASE and three in `ST_SETTLE`. The captured values appear on the outputs right after that edge.
- R3: `strap_mode_pin` = 1 at capture gives `code_internal` = 1 (on-chip code). `strap_mode_pin` = 0 gives `code_internal` = 0 (external code).
- R4: `strap_width_pin` = 1 at capture gives `bus_wide` = 1 (16-bit bus). `strap_width_pin` = 0 gives `bus_wide` = 0 (8-bit bus).
- R5: `width_pullup_en` is 1 from reset assertion until capture, and 0 after capture.
- R6: `bus_wait` is 0 until capture. After capture it follows `strap_mode_pin` combinationally.
- R7: After capture, changes on either strap pin have no effect on `code_internal` or `bus_wide`.
- R8: After capture, `sw_wr_en` = 1 at a rising edge loads `sw_wr_data` into `bus_wide`. `code_internal` does not change.
- R9: Software writes made before capture are ignored. `bus_wide` stays at its reset value.
- R10: Raising `rst_raw` returns all four outputs to their reset values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_raw | input | 1 | Raw active-high reset, asynchronous |
| strap_mode_pin | input | 1 | Code-mode strap pin; bus-wait input after capture |
| strap_width_pin | input | 1 | Bus-width strap pin |
| sw_wr_en | input | 1 | Software write strobe for the bus width |
| sw_wr_data | input | 1 | Software bus-width value (1 = 16-bit) |
| code_internal | output | 1 | 1 = on-chip code, 0 = external code |
| bus_wide | output | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| bus_wait | output | 1 | Active-high bus wait, 0 until capture |
| width_pullup_en | output | 1 | Weak pull-up request for the width pin |

## Verification
The bound checker tests on every cycle that:
- both flags hold their defaults outside `ST_RUN`;
- the values latched on entry to `ST_RUN` match the pin levels of the previous cycle;
- `code_internal` stays frozen in `ST_RUN`;
- a software write lands one cycle later;
- the wait output is silent while the pull-up is requested;
- the synchronised reset always requests the pull-up.

The exact six-edge capture latency seen at the ports, the ignoring of early writes and the asynchronous return to defaults are shown only by the bench's timed scenarios.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } strap_state_e;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_raw,
    output logic rst_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    // Asynchronous assert, release shifted through STAGES flops
    always_ff @(posedge clk or posedge rst_raw) begin
        if (rst_raw) begin
            chain <= '1;
        end else begin
            chain <= {chain[LAST-1:0], 1'b0};
        end
    end

    assign rst_sync = chain[LAST];
endmodule

// File: rtl/strap_window_ctr.sv
module strap_window_ctr #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_raw,
    input  logic strap_mode_pin,
    input  logic strap_width_pin,
    input  logic sw_wr_en,
    input  logic sw_wr_data,
    output logic code_internal,
    output logic bus_wide,
    output logic bus_wait,
    output logic width_pullup_en
);
    strap_state_e state, state_nx;
    logic         rst_sync;
    logic         win_done;
    logic         code_q;
    logic         wide_q;

    strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_raw  (rst_raw),
        .rst_sync (rst_sync)
    );

    strap_window_ctr #(.CYCLES(SETTLE_CYCLES)) u_win (
        .clk  (clk),
        .rst  (rst_sync),
        .run  (state == ST_SETTLE),
        .done (win_done)
    );

    // State register (T_RESET is the asynchronous path)
    always_ff @(posedge clk or posedge rst_sync) begin
        if (rst_sync) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic: T_RELEASE, T_CAPTURE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:   state_nx = ST_SETTLE;
            ST_SETTLE: if (win_done) state_nx = ST_RUN;
            ST_RUN:    state_nx = ST_RUN;
            default:   state_nx = ST_HOLD;
        endcase
    end

    // Captured configuration, software override of the width
    always_ff @(posedge clk or posedge rst_sync) begin
        if (rst_sync) begin
            code_q <= 1'b1;
            wide_q <= 1'b1;
        end else if (state == ST_SETTLE && win_done) begin
            code_q <= strap_mode_pin;
            wide_q <= strap_width_pin;
        end else if (state == ST_RUN && sw_wr_en) begin
            wide_q <= sw_wr_data;
        end
    end

    // Outputs
    always_comb begin
        code_internal   = code_q;
        bus_wide        = wide_q;
        bus_wait        = 1'b0;
        width_pullup_en = 1'b1;
        unique case (state)
            ST_HOLD, ST_SETTLE: begin
                bus_wait        = 1'b0;
                width_pullup_en = 1'b1;
            end
            ST_RUN: begin
                bus_wait        = strap_mode_pin;
                width_pullup_en = 1'b0;
            end
            default: begin
                bus_wait        = 1'b0;
                width_pullup_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk
    import strap_pkg::*;
(
    input logic         clk,
    input logic         rst_raw,
    input logic         rst_sync,
    input strap_state_e state,
    input logic         strap_mode_pin,
    input logic         strap_width_pin,
    input logic         sw_wr_en,
    input logic         sw_wr_data,
    input logic         code_internal,
    input logic         bus_wide,
    input logic         bus_wait,
    input logic         width_pullup_en
);
    p_defaults_r1: assert property (@(posedge clk) disable iff (rst_raw)
        (state != ST_RUN) |-> (code_internal && bus_wide));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst_raw)
        $rose(state == ST_RUN) |->
            (bus_wide == $past(strap_width_pin)) && (code_internal == $past(strap_mode_pin)));

    p_pullup_reset_r5: assert property (@(posedge clk) disable iff (rst_raw)
        rst_sync |-> width_pullup_en);

    p_wait_quiet_r6: assert property (@(posedge clk) disable iff (rst_raw)
        width_pullup_en |-> !bus_wait);

    p_code_frozen_r7: assert property (@(posedge clk) disable iff (rst_raw)
        (state == ST_RUN && $past(state == ST_RUN)) |-> $stable(code_internal));

    p_sw_write_r8: assert property (@(posedge clk) disable iff (rst_raw)
        (state == ST_RUN && sw_wr_en) |=> (bus_wide == $past(sw_wr_data)));
endmodule

bind strap_latch strap_latch_chk u_chk (
    .clk             (clk),
    .rst_raw         (rst_raw),
    .rst_sync        (rst_sync),
    .state           (state),
    .strap_mode_pin  (strap_mode_pin),
    .strap_width_pin (strap_width_pin),
    .sw_wr_en        (sw_wr_en),
    .sw_wr_data      (sw_wr_data),
    .code_internal   (code_internal),
    .bus_wide        (bus_wide),
    .bus_wait        (bus_wait),
    .width_pullup_en (width_pullup_en)
);

// File: tb/sim_strap_latch.sv
`timescale 1ns/1ps
module sim_strap_latch;
    logic clk = 1'b0;
    logic rst_raw = 1'b1;
    logic strap_mode_pin = 1'b1;
    logic strap_width_pin = 1'b1;
    logic sw_wr_en = 1'b0;
    logic sw_wr_data = 1'b0;
    logic code_internal, bus_wide, bus_wait, width_pullup_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    strap_latch u0 (
        .clk             (clk),
        .rst_raw         (rst_raw),
        .strap_mode_pin  (strap_mode_pin),
        .strap_width_pin (strap_width_pin),
        .sw_wr_en        (sw_wr_en),
        .sw_wr_data      (sw_wr_data),
        .code_internal   (code_internal),
        .bus_wide        (bus_wide),
        .bus_wait        (bus_wait),
        .width_pullup_en (width_pullup_en)
    );

    // Fields: [6] mode pin, [5] width pin, [4] write enable, [3] write data,
    //         [2] expected code flag, [1] expected width after capture,
    //         [0] expected width after the write
    localparam logic [6:0] VEC [4] = '{
        7'b1_1_1_0_1_1_0,
        7'b0_1_0_0_0_1_1,
        7'b1_0_1_1_1_0_1,
        7'b0_0_0_1_0_0_0
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Reset with given pins, release, stop at the negedge after the fifth edge
    task automatic release_to_window_end(input logic m, input logic w);
        @(negedge clk);
        rst_raw = 1'b1;
        strap_mode_pin = m;
        strap_width_pin = w;
        repeat (2) @(negedge clk);
        rst_raw = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset code", code_internal, 1'b1);
        check("R1", "reset wide", bus_wide, 1'b1);
        check("R5", "reset pullup", width_pullup_en, 1'b1);
        check("R6", "reset wait", bus_wait, 1'b0);

        for (int i = 0; i < 4; i++) begin
            logic m, w;
            m = VEC[i][6];
            w = VEC[i][5];
            release_to_window_end(m, w);
            check("R1", "window code", code_internal, 1'b1);
            check("R1", "window wide", bus_wide, 1'b1);
            check("R5", "window pullup", width_pullup_en, 1'b1);
            check("R6", "window wait", bus_wait, 1'b0);
            @(posedge clk);
            @(negedge clk);
            check("R2", "capture code", code_internal, VEC[i][2]);
            check("R3", "code mode", code_internal, m);
            check("R4", "bus width", bus_wide, VEC[i][1]);
            check("R5", "pullup off", width_pullup_en, 1'b0);
            check("R6", "wait follows", bus_wait, m);
            strap_mode_pin = ~m;
            strap_width_pin = ~w;
            @(posedge clk);
            @(negedge clk);
            check("R7", "code held", code_internal, VEC[i][2]);
            check("R7", "wide held", bus_wide, VEC[i][1]);
            check("R6", "wait follows new", bus_wait, ~m);
            sw_wr_en = VEC[i][4];
            sw_wr_data = VEC[i][3];
            @(posedge clk);
            @(negedge clk);
            sw_wr_en = 1'b0;
            check("R8", "sw width", bus_wide, VEC[i][0]);
            check("R8", "code untouched", code_internal, VEC[i][2]);
        end

        // R9: write inside the window is ignored
        @(negedge clk);
        rst_raw = 1'b1;
        strap_mode_pin = 1'b1;
        strap_width_pin = 1'b1;
        repeat (2) @(negedge clk);
        rst_raw = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sw_wr_en = 1'b1;
        sw_wr_data = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sw_wr_en = 1'b0;
        check("R9", "early write ignored", bus_wide, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "width after capture", bus_wide, 1'b1);

        // R10: asynchronous return to defaults
        release_to_window_end(1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R3", "external code", code_internal, 1'b0);
        #1;
        rst_raw = 1'b1;
        #1;
        check("R10", "async code", code_internal, 1'b1);
        check("R10", "async wide", bus_wide, 1'b1);
        check("R10", "async pullup", width_pullup_en, 1'b1);
        check("R10", "async wait", bus_wait, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule